// File: doc/BRIEF.md
# Serial Character Transmitter with Integer Bit-Rate Divider

This block turns bytes into asynchronous serial frames on a single output line. Software or a neighbouring block pushes characters into an internal queue. The serializer takes them one at a time and sends each one as a frame: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Every bit lasts the same whole number of clock cycles, and that number comes from a 16-bit divider.

The frame format and the divider are plain configuration inputs. They are captured at the moment a frame begins, so changing them has no effect on a frame that is already being sent. A break control pulls the line low. An optional clear-to-send input can hold back the next frame, but it never cuts a frame short.

The block reports two status conditions:
- queue empty;
- completely idle, which also requires that the last stop bit has left the line.

It also keeps a sticky flag for bytes that were lost because the queue was full, and it raises a request line while the queue is empty.

The character input is a write strobe, not a valid/ready stream. A write made while `fifo_full` is high is dropped and sets the sticky flag, so the only back-pressure is `fifo_full`, which the writer is expected to honour.

Top module: `uart_tx_core`

## Requirements
- R1: A frame is one low start bit, then N = 5 + `word_len` data bits sent least significant bit first (`word_len` 0,1,2,3 gives 5,6,7,8 bits, taken from `wr_data[N-1:0]`), then the optional parity bit, then the stop bits. The line rests high when idle.
- R2: With `par_en`=1 and `par_stick`=0, a parity bit follows the data. It makes the count of ones over data plus parity even when `par_even`=1 and odd when `par_even`=0. With `par_en`=0 no parity bit is sent.
- R3: With `par_en`=1 and `par_stick`=1, the parity bit is the inverse of `par_even`, whatever the data.
- R4: One stop bit is sent when `two_stop`=0 and two when `two_stop`=1, each a full bit long.
- R5: Every bit lasts D+2 clock cycles, where D is `divisor`. Values of `divisor` below 11 are treated as 11, so the bit lasts 13 cycles.
- R6: Frames start only while `div_mode` equals 3. With any other value, queued bytes stay queued and the line stays high.
- R7: While `brk`=1, `txd` is low, no matter what the serializer is doing.
- R8: With `cts_auto`=1 and `cts_n`=1, no new frame starts, but a frame already in progress completes. With `cts_auto`=0, `cts_n` is ignored.
- R9: `fifo_empty` is high when the queue holds no byte. `tx_empty` is high only when the queue is empty and the last stop bit of the final frame has ended.
- R10: A write while `fifo_full`=1 is dropped and sets `ovf_flag`. The flag stays set until a cycle with `ovf_clr`=1 and no new dropped write.
- R11: `thre_irq` equals `thre_ie` AND `fifo_empty`.
- R12: After reset: `txd`=1, `fifo_empty`=1, `tx_empty`=1, `fifo_full`=0, `ovf_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to queue |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH bytes |
| word_len | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | Send two stop bits |
| par_en | input | 1 | Send a parity bit |
| par_even | input | 1 | Even parity select (stick value is its inverse) |
| par_stick | input | 1 | Fixed parity bit |
| brk | input | 1 | Force the line low |
| div_mode | input | 2 | Divider mode; only 3 runs the transmitter |
| divisor | input | 16 | Bit period minus two, in clocks |
| cts_auto | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| ovf_clr | input | 1 | Clear the overflow flag |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| thre_ie | input | 1 | Enable the empty-queue request |
| thre_irq | output | 1 | Empty-queue request |
| fifo_empty | output | 1 | Queue empty |
| tx_empty | output | 1 | Queue empty and line idle |
| txd | output | 1 | Serial output |

## Verification
A bit counter or a state register that goes wrong shows up at the ports as a frame of the wrong length. The effect appears within one bit period:
- a missing or extra data, parity or stop bit makes the bench's mid-bit sample at that position disagree;
- a stop-bit count error moves the rise of `tx_empty` by a whole bit, which shows at the sample taken just after the expected end of the frame.

A bad period counter stretches or shortens the start bit, which the bench measures directly. Faults in the queue pointers or in the drop logic show up as a wrong byte on the line, or as an extra frame after a deliberate overflow.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } frame_cfg_t;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full); // R10
endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] divisor,
  input  logic             run,
  output logic             tick
);
  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] div_q, eff;
  logic [CW-1:0]    cnt, last;

  assign eff  = (div_q < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_q;
  assign last = {1'b0, eff} + CW'(1);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(MIN_DIV);
      cnt   <= '0;
    end else begin
      if (load) div_q <= divisor;
      if (!run || tick) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last)); // R5
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0)); // R5
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       can_start,
  input  logic [7:0] data,
  input  frame_cfg_t cfg,
  input  logic       tick,
  input  logic       brk,
  output logic       pop,
  output logic       busy,
  output logic       txd
);
  tx_state_e  state;
  logic [7:0] shreg;
  logic [2:0] bitcnt;
  logic [1:0] wlen_q;
  logic       two_q, pen_q, par_q;
  logic       last_stop, line, par_new;
  logic [7:0] mask;

  assign last_stop = !two_q || (bitcnt == 3'd1);
  assign pop = can_start &&
               ((state == ST_IDLE) || (state == ST_STOP && tick && last_stop));
  assign busy = (state != ST_IDLE);

  assign mask = 8'hFF >> (2'd3 - cfg.wlen);
  always_comb begin
    if (cfg.par_stick) par_new = !cfg.par_even;
    else if (cfg.par_even) par_new = ^(data & mask);
    else par_new = ~^(data & mask);
  end

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end
  assign txd = line && !brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      wlen_q <= '0;
      two_q  <= 1'b0;
      pen_q  <= 1'b0;
      par_q  <= 1'b0;
    end else if (pop) begin
      state  <= ST_START;
      shreg  <= data;
      bitcnt <= '0;
      wlen_q <= cfg.wlen;
      two_q  <= cfg.two_stop;
      pen_q  <= cfg.par_en;
      par_q  <= par_new;
    end else if (tick) begin
      case (state)
        ST_START: begin
          state  <= ST_DATA;
          bitcnt <= '0;
        end
        ST_DATA: begin
          shreg <= shreg >> 1;
          if (bitcnt == 3'd4 + {1'b0, wlen_q}) begin
            state  <= pen_q ? ST_PAR : ST_STOP;
            bitcnt <= '0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_PAR: begin
          state  <= ST_STOP;
          bitcnt <= '0;
        end
        ST_STOP: begin
          if (last_stop) state <= ST_IDLE;
          else bitcnt <= bitcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (line == 1'b0)); // R1
  AST_IDLE_NO_TICK_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !pop) |=> $stable(state)); // R5
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16,
  parameter int MIN_DIV    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             fifo_full,
  input  logic [1:0]       word_len,
  input  logic             two_stop,
  input  logic             par_en,
  input  logic             par_even,
  input  logic             par_stick,
  input  logic             brk,
  input  logic [1:0]       div_mode,
  input  logic [DIV_W-1:0] divisor,
  input  logic             cts_auto,
  input  logic             cts_n,
  input  logic             ovf_clr,
  output logic             ovf_flag,
  input  logic             thre_ie,
  output logic             thre_irq,
  output logic             fifo_empty,
  output logic             tx_empty,
  output logic             txd
);
  localparam logic [1:0] DIRECT_MODE = 2'd3;

  logic       f_empty, f_drop, pop, tick, busy, can_start, mode_ok, cts_ok;
  logic [7:0] f_dout;
  frame_cfg_t cfg;

  assign cfg = '{wlen: word_len, two_stop: two_stop, par_en: par_en,
                 par_even: par_even, par_stick: par_stick};

  assign mode_ok   = (div_mode == DIRECT_MODE);
  assign cts_ok    = !cts_auto || !cts_n;
  assign can_start = !f_empty && mode_ok && cts_ok;

  uart_tx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(pop),
    .dout(f_dout), .full(fifo_full), .empty(f_empty), .drop(f_drop)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .load(pop), .divisor(divisor),
    .run(busy), .tick(tick)
  );

  uart_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .can_start(can_start), .data(f_dout),
    .cfg(cfg), .tick(tick), .brk(brk), .pop(pop), .busy(busy), .txd(txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (f_drop)  ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  assign fifo_empty = f_empty;
  assign tx_empty   = f_empty && !busy;
  assign thre_irq   = thre_ie && f_empty;

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mode_ok) |=> !busy); // R6
  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cts_auto && cts_n) |=> !busy); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R10
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk) |-> txd); // R9
endmodule

// File: tb/uart_tx_core_test.sv
module uart_tx_core_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0; logic [7:0] wr_data = '0;
  logic [1:0] word_len = 2'd3;
  logic two_stop = 0, par_en = 0, par_even = 0, par_stick = 0, brk = 0;
  logic [1:0] div_mode = 2'd3; logic [15:0] divisor = 16'd11;
  logic cts_auto = 0, cts_n = 0, ovf_clr = 0, thre_ie = 0;
  logic fifo_full, ovf_flag, thre_irq, fifo_empty, tx_empty, txd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_tx_core uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
    .word_len(word_len), .two_stop(two_stop), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .brk(brk), .div_mode(div_mode), .divisor(divisor),
    .cts_auto(cts_auto), .cts_n(cts_n), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
    .thre_ie(thre_ie), .thre_irq(thre_irq), .fifo_empty(fifo_empty),
    .tx_empty(tx_empty), .txd(txd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int period_of(input logic [15:0] d);
    return ((d < 16'd11) ? 11 : int'(d)) + 2;
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input int nb, input logic ev, input logic st);
    logic [7:0] m;
    m = d & 8'((1 << nb) - 1);
    if (st) return !ev;
    return ev ? ^m : ~^m;
  endfunction

  task automatic write_byte(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && tx_empty !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic check_frame(input logic [7:0] d, input bit tail);
    int nb, p, to;
    nb = 5 + int'(word_len);
    p  = period_of(divisor);
    to = 0;
    while (txd !== 1'b0 && to < 5000) begin @(negedge clk); to++; end
    check("R1 start seen", 32'(to < 5000), 1);
    repeat (p / 2) @(negedge clk);
    check("R1 start bit", 32'(txd), 0);
    for (int i = 0; i < nb; i++) begin
      repeat (p) @(negedge clk);
      check("R1 data bit", 32'(txd), 32'(d[i]));
    end
    if (par_en) begin
      repeat (p) @(negedge clk);
      check(par_stick ? "R3 stick parity" : "R2 parity", 32'(txd), 32'(exp_par(d, nb, par_even, par_stick)));
    end
    repeat (p) @(negedge clk);
    check("R4 stop bit 1", 32'(txd), 1);
    if (two_stop) begin
      repeat (p) @(negedge clk);
      check("R4 stop bit 2", 32'(txd), 1);
    end
    if (tail) begin
      check("R9 queue empty in last stop", 32'(fifo_empty), 1);
      check("R4 R9 not idle in last stop", 32'(tx_empty), 0);
      repeat (p / 2 + 2) @(negedge clk);
      check("R9 idle after frame", 32'(tx_empty), 1);
    end
  endtask

  task automatic measure_start(input logic [15:0] dv);
    int n, to;
    divisor = dv; word_len = 2'd3; par_en = 0;
    write_byte(8'hFF);
    to = 0;
    while (txd !== 1'b0 && to < 5000) begin @(negedge clk); to++; end
    n = 0;
    while (txd === 1'b0 && n < 100000) begin n++; @(negedge clk); end
    check("R5 bit length", 32'(n), 32'(period_of(dv)));
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 txd", 32'(txd), 1);
    check("R12 fifo_empty", 32'(fifo_empty), 1);
    check("R12 tx_empty", 32'(tx_empty), 1);
    check("R12 fifo_full", 32'(fifo_full), 0);
    check("R12 ovf_flag", 32'(ovf_flag), 0);

    // R5 bit period, including clamp below the minimum
    measure_start(16'd3);
    measure_start(16'd20);

    // Directed: stick parity both polarities (R3), odd parity (R2), two stops (R4)
    divisor = 16'd11; word_len = 2'd0; par_en = 1; par_stick = 1; par_even = 0; two_stop = 1;
    write_byte(8'h1F); check_frame(8'h1F, 1);
    par_even = 1; write_byte(8'h00); check_frame(8'h00, 1);
    par_stick = 0; par_even = 0; two_stop = 0; word_len = 2'd2;
    write_byte(8'h55); check_frame(8'h55, 1);

    // Constrained random frames
    for (int k = 0; k < 24; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      word_len = 2'($urandom); two_stop = 1'($urandom); par_en = 1'($urandom);
      par_even = 1'($urandom); par_stick = 1'($urandom);
      divisor = ($urandom % 5 == 0) ? 16'($urandom % 11) : 16'(11 + $urandom % 14);
      write_byte(d);
      check_frame(d, 1);
    end

    // R7 break
    brk = 1; #1; check("R7 break low", 32'(txd), 0);
    @(negedge clk); brk = 0; #1; check("R7 break release", 32'(txd), 1);

    // R11 request line
    thre_ie = 1; #1; check("R11 irq empty", 32'(thre_irq), 1);
    word_len = 2'd3; par_en = 0; two_stop = 0; divisor = 16'd11;

    // R6 mode gating
    div_mode = 2'd0;
    write_byte(8'hA5);
    #1; check("R11 irq with data", 32'(thre_irq), 0);
    thre_ie = 0; #1; check("R11 irq disabled", 32'(thre_irq), 0);
    repeat (200) @(negedge clk);
    check("R6 held line", 32'(txd), 1);
    check("R6 held queue", 32'(fifo_empty), 0);
    check("R6 held busy", 32'(tx_empty), 0);
    div_mode = 2'd3;
    check_frame(8'hA5, 1);

    // R8 clear-to-send
    cts_auto = 1; cts_n = 1;
    write_byte(8'h3C);
    repeat (100) @(negedge clk);
    check("R8 held", 32'(txd), 1);
    check("R8 held queue", 32'(fifo_empty), 0);
    cts_n = 0;
    check_frame(8'h3C, 1);
    write_byte(8'hC3); write_byte(8'h96);
    @(negedge clk);
    cts_n = 1;
    check_frame(8'hC3, 0);
    repeat (3 * period_of(divisor)) @(negedge clk);
    check("R8 second held line", 32'(txd), 1);
    check("R8 second held queue", 32'(fifo_empty), 0);
    cts_n = 0;
    check_frame(8'h96, 1);
    cts_auto = 0; cts_n = 1;
    write_byte(8'h81);
    check_frame(8'h81, 1);
    cts_n = 0;

    // R10 overflow
    div_mode = 2'd0;
    for (int i = 0; i < DEPTH; i++) write_byte(8'(i + 1));
    check("R10 full", 32'(fifo_full), 1);
    check("R10 no flag yet", 32'(ovf_flag), 0);
    write_byte(8'hEE);
    check("R10 flag set", 32'(ovf_flag), 1);
    repeat (5) @(negedge clk);
    check("R10 flag sticky", 32'(ovf_flag), 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    check("R10 flag cleared", 32'(ovf_flag), 0);
    div_mode = 2'd3;
    for (int i = 0; i < DEPTH; i++) check_frame(8'(i + 1), i == DEPTH - 1);
    repeat (50) @(negedge clk);
    check("R10 dropped byte not sent", 32'(tx_empty), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule